// File: doc/BRIEF.md
# Streaming Systematic Reed-Solomon Encoder

This block turns a stream of 8-bit information symbols into Reed-Solomon codewords over GF(2^8). It builds the field from the polynomial x^8+x^4+x^3+x^2+1 (0x11D). The generator polynomial has the roots alpha^0 to alpha^(P-1), where P = N-K, and its coefficients are worked out at elaboration from the parameters. A block opens with a byte that carries the start flag. The next K-1 accepted bytes complete the information part. Every information byte goes out unchanged in the same cycle it is accepted, while a bank of P parity stages divides the message by the generator. After the K-th byte the input side closes, the P parity symbols are emitted highest stage first, and then the input side opens again. Shortened codes, such as the default K=188, N=204, are chosen through the parameters alone.

Both stream sides use valid/ready. An input byte is taken on a cycle where `in_valid` and `in_ready` are both high. An output byte is taken on a cycle where `out_valid` and `out_ready` are both high. During the information phase the path is a straight pass-through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid` for bytes that belong to a block. Back-pressure therefore reaches upstream in the same cycle. During the parity phase `in_ready` is low and `out_valid` is high. A parity symbol is held, unchanged, until `out_ready` accepts it. Each output byte carries a 2-bit kind code, plus flags that mark the first and the last byte of the codeword. Reset is synchronous and active high.

Top module: `rs_frame_enc`

## Requirements
- R1: In the cycle after reset is released with no input, out_valid is 0, out_kind is 0, out_first is 0, and in_ready equals out_ready.
- R2: In the information phase in_ready equals out_ready. A block byte presented with in_valid appears on out_data unchanged in the same cycle, with out_valid 1 and out_kind 1.
- R3: out_first is 1 only with the first information byte of a block, which is the byte presented with in_first.
- R4: Once the K-th information byte is accepted, the next P = N-K output beats carry parity with out_kind 2 and in_ready 0. The N accepted output bytes form a codeword whose syndromes at alpha^0 to alpha^(P-1) (field polynomial 0x11D) are all zero, with the information byte taken first as the highest-degree coefficient.
- R5: out_last is 1 only on the P-th parity byte. The cycle after that byte is accepted, the block is back in the information phase.
- R6: While a parity byte is presented and out_ready is 0, the byte, its kind and its flags stay unchanged in the next cycle.
- R7: A byte presented without in_first when no block is open is consumed (in_ready is 1) but produces no output (out_valid 0, out_kind 0) and does not open a block.
- R8: A byte with in_first that arrives inside an open information phase restarts the block. The parity state is cleared and the count starts again from that byte.
- R9: out_kind is 0 on every cycle where out_valid is 0.
- R10: A synchronous reset in the middle of a block discards it. Afterwards the encoder is idle, as in R1, and the next block is encoded from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Encoder takes the input byte this cycle |
| in_first | input | 1 | Input byte opens a new block |
| in_data | input | 8 | Information symbol |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte this cycle |
| out_data | output | 8 | Information or parity symbol |
| out_first | output | 1 | First byte of the codeword |
| out_last | output | 1 | Last parity byte of the codeword |
| out_kind | output | 2 | 0 idle, 1 information, 2 parity |

## Verification
Information bytes have zero latency: they reach out_data in the same cycle they are offered. The first parity byte is due in the cycle after the K-th handshake, and each later parity byte follows one cycle after each accepted beat. The bench drives its inputs at the falling edge and compares every output one time unit later against a behavioural model. That model advances only at the rising edge, so each expected value is tied to the cycle in which it is due. Apart from that cycle-exact comparison, every complete codeword collected from the outputs is checked by syndrome evaluation, with data patterns, gaps and stalls varied between blocks.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;  // x^8 term implied: 0x11D

  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_INFO = 2'd1,
    KIND_PAR  = 2'd2
  } kind_e;

  // Shift-and-add product in GF(2^8)
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = {aa[SYM_W-2:0], 1'b0} ^ (aa[SYM_W-1] ? FIELD_LOW : '0);
    end
    return acc;
  endfunction

  function automatic sym_t gf_alpha_pow(int e);
    sym_t x;
    x = 8'd1;
    for (int i = 0; i < e; i++) x = gf_mul(x, 8'd2);
    return x;
  endfunction

  // Coefficient idx of prod_{i<nroots} (x + alpha^i); nroots must be below 256
  function automatic sym_t gen_coef(int nroots, int idx);
    sym_t g [256];
    sym_t r;
    for (int j = 0; j < 256; j++) g[j] = '0;
    g[0] = 8'd1;
    for (int i = 0; i < nroots; i++) begin
      r = gf_alpha_pow(i);
      for (int j = i + 1; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], r);
      g[0] = gf_mul(g[0], r);
    end
    return g[idx];
  endfunction
endpackage

// File: rtl/rs_parity_reg.sv
module rs_parity_reg
  import rs_enc_pkg::*;
#(
  parameter int NROOTS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clr,
  input  logic shift,
  input  sym_t din,
  output sym_t top
);
  logic [NROOTS-1:0][SYM_W-1:0] stage;
  logic [NROOTS-1:0][SYM_W-1:0] nxt;
  sym_t fb;

  // A restarting byte sees an empty register
  assign fb = din ^ (clr ? '0 : stage[NROOTS-1]);

  generate
    for (genvar i = 0; i < NROOTS; i++) begin : g_stage
      localparam sym_t GC = gen_coef(NROOTS, i);
      sym_t below;
      if (i == 0) begin : g_lo
        assign below = '0;
      end else begin : g_up
        assign below = stage[i-1];
      end
      assign nxt[i] = load  ? ((clr ? '0 : below) ^ gf_mul(fb, GC)) :
                      shift ? below : stage[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= nxt;
  end

  assign top = stage[NROOTS-1];

  // R6
  stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(top));
endmodule

// File: rtl/rs_frame_ctrl.sv
module rs_frame_ctrl
  import rs_enc_pkg::*;
#(
  parameter int K = 188,
  parameter int N = 204
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  logic  in_first,
  input  logic  out_ready,
  output logic  in_ready,
  output logic  out_valid,
  output logic  out_first,
  output logic  out_last,
  output kind_e kind,
  output logic  load,
  output logic  clr,
  output logic  shift,
  output logic  sel_par
);
  localparam int P   = N - K;
  localparam int CW  = $clog2(K + 1);
  localparam int PCW = (P > 1) ? $clog2(P) : 1;

  typedef enum logic {PH_INFO, PH_PAR} phase_e;

  phase_e         phase;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  cnt_nxt;
  logic [PCW-1:0] pcnt;
  logic           in_block;

  assign in_block  = in_first || (cnt != '0);
  assign sel_par   = (phase == PH_PAR);
  assign in_ready  = !sel_par && out_ready;
  assign out_valid = sel_par || (in_valid && in_block);
  assign load      = in_valid && in_ready && in_block;
  assign clr       = in_first;
  assign shift     = sel_par && out_ready;
  assign out_first = !sel_par && in_valid && in_first;
  assign out_last  = sel_par && (pcnt == PCW'(P - 1));
  assign cnt_nxt   = in_first ? CW'(1) : cnt + CW'(1);

  always_comb begin
    if (sel_par)        kind = KIND_PAR;
    else if (out_valid) kind = KIND_INFO;
    else                kind = KIND_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_INFO;
      cnt   <= '0;
      pcnt  <= '0;
    end else if (phase == PH_INFO) begin
      if (load) begin
        if (cnt_nxt == CW'(K)) begin
          phase <= PH_PAR;
          cnt   <= '0;
          pcnt  <= '0;
        end else begin
          cnt <= cnt_nxt;
        end
      end
    end else if (out_ready) begin
      if (pcnt == PCW'(P - 1)) begin
        phase <= PH_INFO;
        pcnt  <= '0;
      end else begin
        pcnt <= pcnt + PCW'(1);
      end
    end
  end

  // R5
  last_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (kind != KIND_PAR) && in_ready == out_ready);
  // R6
  par_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == KIND_PAR && !out_ready) |=> (kind == KIND_PAR) && $stable(out_last));
  // R3
  first_is_info_chk: assert property (@(posedge clk) disable iff (rst)
    out_first |-> (kind == KIND_INFO));
  // R9
  idle_kind_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (kind == KIND_IDLE));
endmodule

// File: rtl/rs_frame_enc.sv
module rs_frame_enc
  import rs_enc_pkg::*;
#(
  parameter int K = 188,
  parameter int N = 204
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_first,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last,
  output logic [1:0] out_kind
);
  localparam int P = N - K;

  logic  load, clr, shift, sel_par;
  kind_e kind;
  sym_t  par_top;

  rs_frame_ctrl #(.K(K), .N(N)) u_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_first(in_first), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid),
    .out_first(out_first), .out_last(out_last), .kind(kind),
    .load(load), .clr(clr), .shift(shift), .sel_par(sel_par)
  );

  rs_parity_reg #(.NROOTS(P)) u_par (
    .clk(clk), .rst(rst),
    .load(load), .clr(clr), .shift(shift),
    .din(in_data), .top(par_top)
  );

  assign out_data = sel_par ? par_top : in_data;
  assign out_kind = kind;

  // Checker counter: accepted parity beats in the current codeword
  localparam int BW = $clog2(P + 1);
  logic [BW-1:0] par_beats;
  always_ff @(posedge clk) begin
    if (rst) par_beats <= '0;
    else if (out_valid && out_ready && out_kind == 2'd2)
      par_beats <= out_last ? '0 : par_beats + BW'(1);
  end

  // R4
  par_count_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> (par_beats == BW'(P - 1)));
  // R4
  par_blocks_in_chk: assert property (@(posedge clk) disable iff (rst)
    (out_kind == 2'd2) |-> !in_ready && out_valid);
  // R6
  par_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_kind == 2'd2 && !out_ready) |=> $stable(out_data));
  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (out_kind == 2'd1) |-> (out_data == in_data) && in_valid);
endmodule

// File: tb/rs_frame_enc_bench.sv
module rs_frame_enc_bench;
  localparam int K = 188;
  localparam int N = 204;
  localparam int P = N - K;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_first, out_last;
  logic [7:0] out_data;
  logic [1:0] out_kind;

  always #5 clk = ~clk;

  rs_frame_enc #(.K(K), .N(N)) u_rs_frame_enc (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_kind(out_kind)
  );

  int checks = 0;
  int fails  = 0;

  int gexp [512];
  int glog [256];
  int gen  [P+1];

  function automatic int fmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[glog[a] + glog[b]];
  endfunction

  // behavioural model state
  int m_phase = 0;
  int m_cnt   = 0;
  int m_pidx  = 0;
  int m_info [$];
  int m_par  [P];
  int cw     [$];

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compute_parity();
    int poly [N];
    for (int t = 0; t < N; t++) poly[t] = 0;
    for (int t = 0; t < K; t++) poly[N-1-t] = m_info[t];
    for (int i = N - 1; i >= P; i--) begin
      int c = poly[i];
      if (c != 0)
        for (int j = 0; j <= P; j++) poly[i-P+j] = poly[i-P+j] ^ fmul(c, gen[j]);
    end
    for (int t = 0; t < P; t++) m_par[t] = poly[P-1-t];
  endtask

  task automatic check_codeword();
    chk("R4", cw.size(), N, "codeword length");
    for (int i = 0; i < P; i++) begin
      int s = 0;
      foreach (cw[t]) s = fmul(s, gexp[i]) ^ cw[t];
      chk("R4", s, 0, $sformatf("syndrome %0d", i));
    end
  endtask

  task automatic cycle(bit v, bit f, int d, bit r);
    bit e_valid, e_ready, e_first, e_last;
    int e_data, e_kind;
    string tg;
    @(negedge clk);
    in_valid = v; in_first = f; in_data = d[7:0]; out_ready = r;
    #1;
    if (m_phase == 0) begin
      e_valid = v && (f || m_cnt != 0);
      e_ready = r;
      e_data  = d & 255;
      e_kind  = e_valid ? 1 : 0;
      e_first = e_valid && f;
      e_last  = 1'b0;
      tg = (v && f && m_cnt != 0) ? "R8" : ((v && !f && m_cnt == 0) ? "R7" : "R2");
    end else begin
      e_valid = 1'b1;
      e_ready = 1'b0;
      e_data  = m_par[m_pidx];
      e_kind  = 2;
      e_first = 1'b0;
      e_last  = (m_pidx == P - 1);
      tg = r ? "R4" : "R6";
    end
    chk(tg, out_valid, e_valid, "out_valid");
    chk(tg, in_ready, e_ready, "in_ready");
    if (e_valid) chk(tg, out_data, e_data, "out_data");
    chk(e_valid ? tg : "R9", out_kind, e_kind, "out_kind");
    chk("R3", out_first, e_first, "out_first");
    chk("R5", out_last, e_last, "out_last");
    if (out_valid && out_ready) begin
      if (out_first) cw.delete();
      cw.push_back(int'(out_data));
      if (out_last) check_codeword();
    end
    @(posedge clk);
    if (m_phase == 0) begin
      if (v && r && (f || m_cnt != 0)) begin
        if (f) begin m_info.delete(); m_cnt = 0; end
        m_info.push_back(d & 255);
        m_cnt++;
        if (m_cnt == K) begin
          compute_parity();
          m_phase = 1; m_pidx = 0; m_cnt = 0;
        end
      end
    end else if (r) begin
      m_pidx++;
      if (m_pidx == P) begin m_phase = 0; m_pidx = 0; end
    end
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_first = 1'b0; out_ready = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_phase = 0; m_cnt = 0; m_pidx = 0; m_info.delete(); cw.delete();
    #1;
    chk(tag, out_valid, 0, "out_valid after reset");
    chk(tag, out_kind, 0, "out_kind after reset");
    chk(tag, in_ready, 1, "in_ready after reset");
    chk(tag, out_first, 0, "out_first after reset");
  endtask

  // mode: 0 ramp, 1 random, 2 all ones, 3 all zeros
  task automatic send_block(int mode, int n, int gap_pct, int stall_pct);
    for (int t = 0; t < n; t++) begin
      int d;
      bit acc;
      case (mode)
        0: d = (t * 7 + 3) & 255;
        1: d = int'($urandom_range(255));
        2: d = 255;
        default: d = 0;
      endcase
      do begin
        bit v = int'($urandom_range(99)) >= gap_pct;
        bit r = int'($urandom_range(99)) >= stall_pct;
        acc = v && r && (m_phase == 0);
        cycle(v, t == 0, d, r);
      end while (!acc);
    end
    if (n == K)
      while (m_phase == 1) cycle(1'b0, 1'b0, 0, int'($urandom_range(99)) >= stall_pct);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int x = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = x; glog[x] = i;
      x = x << 1;
      if ((x & 256) != 0) x = x ^ 'h11D;
    end
    for (int i = 255; i < 512; i++) gexp[i] = gexp[i-255];
    glog[0] = 0;
    for (int j = 0; j <= P; j++) gen[j] = 0;
    gen[0] = 1;
    for (int i = 0; i < P; i++) begin
      for (int j = i + 1; j > 0; j--) gen[j] = gen[j-1] ^ fmul(gen[j], gexp[i]);
      gen[0] = fmul(gen[0], gexp[i]);
    end

    do_reset("R1");
    // idle, with and without downstream ready (R1, R9)
    cycle(1'b0, 1'b0, 0, 1'b1);
    cycle(1'b0, 1'b0, 0, 1'b0);
    cycle(1'b0, 1'b0, 0, 1'b1);
    // stray bytes outside a block are dropped (R7)
    cycle(1'b1, 1'b0, 'h5A, 1'b1);
    cycle(1'b1, 1'b0, 'hA5, 1'b1);
    cycle(1'b1, 1'b0, 'h33, 1'b0);
    // full-rate block (R2 R3 R4 R5)
    send_block(0, K, 0, 0);
    // random data with gaps and stalls (R6)
    send_block(1, K, 30, 30);
    send_block(2, K, 10, 50);
    send_block(3, K, 0, 20);
    // restart inside a block (R8)
    send_block(1, 50, 20, 0);
    send_block(1, K, 20, 20);
    // stray byte right after a block (R7)
    cycle(1'b1, 1'b0, 'h77, 1'b1);
    // reset in mid-block (R10)
    send_block(0, 20, 0, 0);
    do_reset("R10");
    cycle(1'b1, 1'b0, 'h11, 1'b1);
    send_block(1, K, 40, 40);
    // reset during parity drain (R10)
    send_block(1, K - 1, 0, 0);
    cycle(1'b1, 1'b0, 'h42, 1'b1);
    cycle(1'b0, 1'b0, 0, 1'b1);
    do_reset("R10");
    send_block(0, K, 0, 0);
    repeat (3) cycle(1'b0, 1'b0, 0, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule